// File: doc/BRIEF.md
# Programmable Tick Timer with Match Modes

This block is a processor tick timer. It keeps a 32-bit count that advances by one for each cycle in which the tick-enable input is high and counting is active. A control word holds a match period, an interrupt enable, a sticky pending flag and a two-bit run mode. A match occurs when the low period bits of the count reach the programmed period. The upper count bits take no part in this compare. On a match the block can flag an interrupt. Depending on the run mode, it then clears the count, halts it or lets it run on.

Software reaches both registers through a single-cycle write port and a combinational read port. The interrupt output is a level signal. It stays high while the pending flag and the enable are both set. The tick input is meant to pulse at the timer rate (nominally 20 MHz) in the core's clock domain.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0x00000000, irq is 0 and the count does not advance on ticks.
- R2: While the run mode is non-zero and the timer is not halted, each cycle with tickEn high raises the count by one. A cycle with tickEn low leaves the count unchanged.
- R3: A match is a counting tick on which the low 28 bits of (count+1) equal the period field (control bits [27:0]). Count bits [31:28] are ignored. If the period is at or below the current low bits, the match comes only after those bits wrap through zero.
- R4: A match while the enable (bit 29) is 1 sets the pending flag (bit 28). Writing 0 to bit 28 clears the flag. Writing 1 to it does not set it. A match in the same cycle as a clearing write leaves the flag set. With the enable at 0, a match leaves the flag unchanged.
- R5: irq is 1 exactly when the pending flag and the enable are both 1.
- R6: In restart mode (bits [31:30] = 01), a match sets the count to 0.
- R7: In one-shot mode (10), a match loads the count with the matched value and halts counting. The count holds until the next write to the control word.
- R8: In continuous mode (11), the count keeps incrementing through a match.
- R9: A count write (wrSel = 0) loads wrData into the count. It wins over any tick or match effect in that cycle, and counting continues from the loaded value.
- R10: Writing run mode 00 stops counting and the count holds. A control write takes effect from the next cycle. The count update in the write cycle follows the old settings.
- R11: rdData returns the count when rdSel = 0. When rdSel = 1 it returns the control word laid out as {mode[1:0], enable, pending, period[27:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer tick qualifier, one tick per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = count, 1 = control word |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 = count, 1 = control word |
| rdData | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that wrSel and wrData are valid in every cycle with wrEn high. They also assume that at most one register is written per cycle, which the single select line enforces. Each bench step drives one cycle's write, select and tick values at the falling edge, so no input changes near the active edge. Periods are kept small, and the count is preloaded close to the 28-bit wrap. This lets the wrap-around and upper-bit cases fit within a few cycles. Collisions are driven on purpose: a count write on a matching tick, and a pending clear on a matching tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_FREE    = 2'b11
  } runMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic step;
  } cntStrobe_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             modeWr,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [PER_W-1:0] countLow,
  output cntStrobe_t       strobe,
  output logic [CNT_W-1:0] modeWord,
  output logic             running,
  output logic             matchHit,
  output logic             irq
);

  localparam int PEND_BIT = PER_W;
  localparam int EN_BIT   = PER_W + 1;
  localparam int MODE_LSB = PER_W + 2;

  logic [PER_W-1:0] periodQ;
  logic             pendQ;
  logic             enQ;
  runMode_t         modeQ;
  logic             haltQ;
  logic [PER_W-1:0] lowInc;

  assign running  = (modeQ != MODE_OFF) && !haltQ;
  assign lowInc   = countLow + PER_W'(1);
  assign matchHit = running && tickEn && (lowInc == periodQ);

  always_comb begin
    strobe.load  = cntWr;
    strobe.clear = !cntWr && matchHit && (modeQ == MODE_RESTART);
    strobe.step  = !cntWr && running && tickEn && !(matchHit && (modeQ == MODE_RESTART));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
      pendQ   <= 1'b0;
      enQ     <= 1'b0;
      modeQ   <= MODE_OFF;
      haltQ   <= 1'b0;
    end else begin
      pendQ <= (modeWr ? (pendQ & wrData[PEND_BIT]) : pendQ) | (matchHit & enQ);
      if (modeWr) begin
        periodQ <= wrData[PER_W-1:0];
        enQ     <= wrData[EN_BIT];
        modeQ   <= runMode_t'(wrData[MODE_LSB +: 2]);
        haltQ   <= 1'b0;
      end else if (matchHit && (modeQ == MODE_ONESHOT)) begin
        haltQ <= 1'b1;
      end
    end
  end

  always_comb begin
    modeWord                  = '0;
    modeWord[PER_W-1:0]       = periodQ;
    modeWord[PEND_BIT]        = pendQ;
    modeWord[EN_BIT]          = enQ;
    modeWord[MODE_LSB +: 2]   = modeQ;
  end

  assign irq = pendQ & enQ;

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countQ
);

  always_ff @(posedge clk) begin
    if (!rstN)             countQ <= '0;
    else if (strobe.load)  countQ <= loadVal;
    else if (strobe.clear) countQ <= '0;
    else if (strobe.step)  countQ <= countQ + CNT_W'(1);
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] modeWord;
  logic             running;
  logic             matchHit;
  logic             cntWr;
  logic             modeWr;

  assign cntWr  = wrEn & ~wrSel;
  assign modeWr = wrEn & wrSel;

  tick_timer_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .modeWr   (modeWr),
    .cntWr    (cntWr),
    .wrData   (wrData),
    .countLow (countQ[PER_W-1:0]),
    .strobe   (strobe),
    .modeWord (modeWord),
    .running  (running),
    .matchHit (matchHit),
    .irq      (irq)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (wrData),
    .countQ  (countQ)
  );

  assign rdData = rdSel ? modeWord : countQ;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             wrEn,
  input logic             wrSel,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] countQ,
  input logic [CNT_W-1:0] modeWord,
  input logic             running,
  input logic             matchHit,
  input logic             irq
);

  localparam int PEND_BIT = PER_W;
  localparam int EN_BIT   = PER_W + 1;
  localparam int MODE_LSB = PER_W + 2;

  logic [1:0] modeNow;
  assign modeNow = modeWord[MODE_LSB +: 2];

  // R4: pending stays set unless the control word is written
  a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (modeWord[PEND_BIT] && !(wrEn && wrSel)) |=> modeWord[PEND_BIT]);

  // R4: an enabled match always leaves pending set
  a_r4_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && modeWord[EN_BIT]) |=> modeWord[PEND_BIT]);

  // R6: restart match without a count write clears the count
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && modeNow == 2'b01 && !(wrEn && !wrSel)) |=> (countQ == '0));

  // R7: one-shot match without a control write halts counting
  a_r7_oneshot_halt: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && modeNow == 2'b10 && !(wrEn && wrSel)) |=> !running);

  // R9: a count write loads the written value
  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (countQ == $past(wrData)));

  // R10: no counting and no count write means the count holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(running && tickEn) && !(wrEn && !wrSel)) |=> $stable(countQ));

  // R5: the interrupt falls only when pending or enable is removed by a write
  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && wrSel)) |=> irq);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .countQ   (countQ),
  .modeWord (modeWord),
  .running  (running),
  .matchHit (matchHit),
  .irq      (irq)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irq(irq)
  );

  // fields: req, wrEn, wrSel, wrData, tickEn, rdSel, expRd, expIrq
  localparam int NV = 24;
  localparam logic [72:0] VEC [NV] = '{
    {4'd11, 1'b1,1'b1,32'hE0000003, 1'b0,1'b0, 32'h00000000, 1'b0}, // R11 continuous per 3, enabled
    {4'd2,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000001, 1'b0}, // R2
    {4'd2,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000002, 1'b0}, // R2
    {4'd8,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000003, 1'b1}, // R8 match, R4 pend
    {4'd8,  1'b0,1'b0,32'h0,        1'b1,1'b1, 32'hF0000003, 1'b1}, // R8 runs on, R11 layout
    {4'd4,  1'b1,1'b1,32'hE0000003, 1'b0,1'b1, 32'hE0000003, 1'b0}, // R4 clear pend
    {4'd2,  1'b0,1'b0,32'h0,        1'b0,1'b0, 32'h00000004, 1'b0}, // R2 no tick holds
    {4'd9,  1'b1,1'b0,32'h0,        1'b1,1'b0, 32'h00000000, 1'b0}, // R9 load beats tick
    {4'd10, 1'b1,1'b1,32'h40000002, 1'b1,1'b0, 32'h00000001, 1'b0}, // R10 old mode in write cycle
    {4'd6,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000000, 1'b0}, // R6 restart
    {4'd6,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000001, 1'b0}, // R6
    {4'd6,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000000, 1'b0}, // R6
    {4'd4,  1'b0,1'b0,32'h0,        1'b0,1'b1, 32'h40000002, 1'b0}, // R4 disabled: no pend
    {4'd7,  1'b1,1'b1,32'hA0000004, 1'b1,1'b0, 32'h00000001, 1'b0}, // R7 one-shot per 4
    {4'd7,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000002, 1'b0}, // R7
    {4'd7,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000003, 1'b0}, // R7
    {4'd7,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000004, 1'b1}, // R7 match
    {4'd7,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000004, 1'b1}, // R7 halted
    {4'd11, 1'b0,1'b0,32'h0,        1'b1,1'b1, 32'hB0000004, 1'b1}, // R11
    {4'd4,  1'b1,1'b1,32'hB0000004, 1'b1,1'b0, 32'h00000004, 1'b1}, // R4 write 1 keeps, R7 restart
    {4'd7,  1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000005, 1'b1}, // R7 counting again
    {4'd10, 1'b1,1'b1,32'h30000004, 1'b1,1'b0, 32'h00000006, 1'b1}, // R10 stop write
    {4'd10, 1'b0,1'b0,32'h0,        1'b1,1'b0, 32'h00000006, 1'b1}, // R10 stopped
    {4'd5,  1'b1,1'b1,32'h10000004, 1'b0,1'b1, 32'h10000004, 1'b0}  // R5 enable off masks irq
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic ws, input logic [31:0] wd,
                      input logic tk, input logic rs);
    @(negedge clk);
    wrEn = we; wrSel = ws; wrData = wd; tickEn = tk; rdSel = rs;
    @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    rstN = 1'b1;
    // R1: reset state, ticks do not count
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R1 count", rdData, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rdSel = 1'b1; #1;
    check("R1 control", rdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      step(v[68], v[67], v[66:35], v[34], v[33]);
      check($sformatf("R%0d vec %0d rd", v[72:69], i), rdData, v[32:1]);
      check($sformatf("R%0d vec %0d irq", v[72:69], i), {31'b0, irq}, {31'b0, v[0]});
    end

    // R3: wrap of low bits, upper bits ignored; restart per 1, enabled
    rstN = 1'b0;
    step(1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    rstN = 1'b1;
    step(1'b1, 1'b1, 32'h60000001, 1'b0, 1'b0);
    step(1'b1, 1'b0, 32'h0FFFFFFE, 1'b0, 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R3 step1", rdData, 32'h0FFFFFFF);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R3 upper ignored", rdData, 32'h10000000);
    check("R3 no irq yet", {31'b0, irq}, 32'h0);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R3 wrap match", rdData, 32'h0);
    check("R3 irq", {31'b0, irq}, 32'h1);

    // R9: count write on a matching tick wins; restart per 5, disabled
    step(1'b1, 1'b1, 32'h40000005, 1'b0, 1'b0);
    step(1'b1, 1'b0, 32'h00000004, 1'b0, 1'b0);
    step(1'b1, 1'b0, 32'h00000020, 1'b1, 1'b0);
    check("R9 load over match", rdData, 32'h20);
    step(1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R9 continues", rdData, 32'h21);

    // R4: clearing write colliding with an enabled match leaves pending set
    step(1'b1, 1'b1, 32'hE0000003, 1'b0, 1'b0);
    step(1'b1, 1'b0, 32'h00000002, 1'b0, 1'b0);
    step(1'b1, 1'b1, 32'hE0000003, 1'b1, 1'b1);
    check("R4 match beats clear", rdData, 32'hF0000003);
    check("R4 irq", {31'b0, irq}, 32'h1);
    rdSel = 1'b0; #1;
    check("R8 count at match", rdData, 32'h3);

    finishRun();
  end

endmodule